// File: doc/BRIEF.md
# Dual-Stack ALU Execution Unit

This unit is the data-path core of a 21-bit stack machine. It keeps the top of the data stack in a register T and the entries below it in an 18-deep circular data stack. Beside that sit a 17-deep circular return stack and an address register A. Each clock cycle with a valid opcode, it carries out one 5-bit operation. The operation is arithmetic, logic, a shift, a stack shuffle, a data fetch that loads from `data_i`, or a store that retires T.

Bit 20 of the word serves as the carry. Additions run over bits 19..0 and put the carry out in bit 20. The unit drives T as write data and A as a memory address. It also gives two branch conditions to an external sequencer: a zero test on T bits 19..0 and a clear-carry test on T bit 20. Instruction fetch, jumps, memory timing and interrupts live outside this unit. The jump and return codes pass through it with no effect.

Top module: `stack_alu_core`

## Requirements
- R1: After rst_ni is released, T, A and every stack entry are 0. t_zero_o and carry_clr_o are 1, and stack_err_o is 0.
- R2: The codes 0x08, 0x09, 0x0A and 0x0B load data_i into T. Code 0x19 copies A into T, 0x1A copies T into T, and 0x1B copies the next entry into T. Each of these pushes the old T onto the data stack.
- R3: Codes 0x14 (xor), 0x15 (and) and 0x17 (add) combine T with the next entry. The result goes to T and the data stack is popped.
- R4: An add sums bits 19..0 of both operands and ignores their bit 20. The carry out goes to bit 20 of the result.
- R5: Code 0x13 (multiply step) adds the next entry to T when T bit 0 is 1, and otherwise leaves T alone. In both cases the data stack is neither popped nor changed.
- R6: Code 0x11 shifts T left by one and puts 0 into bit 0. Code 0x12 shifts T right by one, keeps bit 20, and copies bit 20 into bit 19.
- R7: Code 0x10 inverts all 21 bits of T.
- R8: Code 0x1C moves T onto the return stack and pops the data stack into T. Code 0x18 moves the top of the return stack into T and pushes the old T.
- R9: Code 0x1D loads A from T and pops the data stack. Codes 0x09 and 0x0D add 1 to A. Codes 0x08 and 0x0C add 1 to the top of the return stack.
- R10: Codes 0x0C, 0x0D, 0x0F (stores) and 0x1F (drop) pop the data stack into T. Code 0x1E, codes 0x00 to 0x07, 0x0E and 0x16, and any cycle with op_valid_i low leave T and A unchanged.
- R11: t_zero_o is 1 exactly when T bits 19..0 are all 0. carry_clr_o is 1 exactly when T bit 20 is 0. Both follow T with no delay.
- R12: Each stack wraps as a ring. A 19th data push overwrites the oldest entry. A push onto a full stack or a pop from an empty stack sets stack_err_o, and it stays set until reset.
- R13: Each operation completes in one clock. Its result appears on the outputs after the rising edge on which it was presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Execute op_i on this edge |
| op_i | input | 5 | Opcode |
| data_i | input | 21 | Literal or fetched word for the load codes |
| wr_data_o | output | 21 | T, used as store data |
| addr_o | output | 21 | Register A |
| t_zero_o | output | 1 | T bits 19..0 are zero |
| carry_clr_o | output | 1 | T bit 20 is zero |
| stack_err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
The adder is tried with several operand pairs. A small sum with no carry shows correct operand order and popping. An all-ones low half plus one must ripple the carry into bit 20. Operands with bit 20 set show that the operand carry bits are ignored. The multiply step is run with T bit 0 clear and then set, which separates a skipped add from a taken one and shows that the next entry stays in place. The right shift is applied twice to a value with only bit 20 set, so sign copying cannot be confused with a plain shift. The stacks are filled to exactly 18 and then to 19 entries, which separates the full boundary from the overflow, and the ring is drained to show that wrapping kept the newer entries.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;
  localparam int unsigned WORD_W = 21;

  typedef enum logic [4:0] {
    OP_FETCH_R_INC = 5'h08,
    OP_FETCH_A_INC = 5'h09,
    OP_LITERAL     = 5'h0A,
    OP_FETCH_A     = 5'h0B,
    OP_STORE_R_INC = 5'h0C,
    OP_STORE_A_INC = 5'h0D,
    OP_STORE_A     = 5'h0F,
    OP_INVERT      = 5'h10,
    OP_SHL         = 5'h11,
    OP_SHR         = 5'h12,
    OP_MUL_STEP    = 5'h13,
    OP_XOR         = 5'h14,
    OP_AND         = 5'h15,
    OP_ADD         = 5'h17,
    OP_R_TO_T      = 5'h18,
    OP_A_TO_T      = 5'h19,
    OP_DUP         = 5'h1A,
    OP_OVER        = 5'h1B,
    OP_T_TO_R      = 5'h1C,
    OP_T_TO_A      = 5'h1D,
    OP_IDLE        = 5'h1E,
    OP_DROP        = 5'h1F
  } op_e;

  typedef struct packed {
    logic d_push;
    logic d_pop;
    logic r_push;
    logic r_pop;
    logic r_set;
    logic a_load;
    logic a_inc;
  } stack_ctl_t;
endpackage

// File: rtl/lifo_ring.sv
module lifo_ring #(
  parameter int unsigned W     = 21,
  parameter int unsigned DEPTH = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic         set_top_i,
  input  logic [W-1:0] wr_i,
  output logic [W-1:0] top_o,
  output logic         err_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] ptr_q, ptr_up, ptr_dn;
  logic [CW-1:0] cnt_q;
  logic          err_q;

  assign ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
  assign top_o  = mem_q[ptr_q];
  assign err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
      ptr_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (push_i) begin
      mem_q[ptr_up] <= wr_i;
      ptr_q         <= ptr_up;
      if (cnt_q == FULL) err_q <= 1'b1;  // oldest entry overwritten
      else               cnt_q <= cnt_q + 1'b1;
    end else if (pop_i) begin
      ptr_q <= ptr_dn;
      if (cnt_q == '0) err_q <= 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (set_top_i) begin
      mem_q[ptr_q] <= wr_i;
    end
  end

  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(wr_i)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R12
  AST_FULL_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt_q == FULL) |=> err_o); // R12
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL); // R12
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import stack_alu_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         valid_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] t_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] t_o,
  output logic [W-1:0] r_wr_o,
  output stack_ctl_t   ctl_o
);
  localparam int unsigned DW = W - 1;  // arithmetic width, top bit is carry

  logic [W-1:0] sum;
  assign sum = {1'b0, t_i[DW-1:0]} + {1'b0, s_i[DW-1:0]};

  always_comb begin
    t_o    = t_i;
    r_wr_o = t_i;
    ctl_o  = '0;
    if (valid_i) begin
      unique case (op_i)
        OP_FETCH_R_INC: begin
          t_o = data_i; ctl_o.d_push = 1'b1;
          ctl_o.r_set = 1'b1; r_wr_o = r_i + 1'b1;
        end
        OP_FETCH_A_INC: begin
          t_o = data_i; ctl_o.d_push = 1'b1; ctl_o.a_inc = 1'b1;
        end
        OP_LITERAL, OP_FETCH_A: begin
          t_o = data_i; ctl_o.d_push = 1'b1;
        end
        OP_STORE_R_INC: begin
          t_o = s_i; ctl_o.d_pop = 1'b1;
          ctl_o.r_set = 1'b1; r_wr_o = r_i + 1'b1;
        end
        OP_STORE_A_INC: begin
          t_o = s_i; ctl_o.d_pop = 1'b1; ctl_o.a_inc = 1'b1;
        end
        OP_STORE_A, OP_DROP: begin
          t_o = s_i; ctl_o.d_pop = 1'b1;
        end
        OP_INVERT:   t_o = ~t_i;
        OP_SHL:      t_o = {t_i[W-2:0], 1'b0};
        OP_SHR:      t_o = {t_i[W-1], t_i[W-1], t_i[W-2:1]};
        OP_MUL_STEP: t_o = t_i[0] ? sum : t_i;
        OP_XOR: begin t_o = t_i ^ s_i; ctl_o.d_pop = 1'b1; end
        OP_AND: begin t_o = t_i & s_i; ctl_o.d_pop = 1'b1; end
        OP_ADD: begin t_o = sum;       ctl_o.d_pop = 1'b1; end
        OP_R_TO_T: begin
          t_o = r_i; ctl_o.d_push = 1'b1; ctl_o.r_pop = 1'b1;
        end
        OP_A_TO_T: begin t_o = a_i; ctl_o.d_push = 1'b1; end
        OP_DUP:    begin t_o = t_i; ctl_o.d_push = 1'b1; end
        OP_OVER:   begin t_o = s_i; ctl_o.d_push = 1'b1; end
        OP_T_TO_R: begin
          t_o = s_i; ctl_o.d_pop = 1'b1; ctl_o.r_push = 1'b1;
        end
        OP_T_TO_A: begin
          t_o = s_i; ctl_o.d_pop = 1'b1; ctl_o.a_load = 1'b1;
        end
        default: ;  // control-flow and unused codes: no datapath effect
      endcase
    end
  end
endmodule

// File: rtl/stack_alu_core.sv
module stack_alu_core
  import stack_alu_pkg::*;
#(
  parameter int unsigned W      = WORD_W,
  parameter int unsigned DDEPTH = 18,
  parameter int unsigned RDEPTH = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         op_valid_i,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] wr_data_o,
  output logic [W-1:0] addr_o,
  output logic         t_zero_o,
  output logic         carry_clr_o,
  output logic         stack_err_o
);
  logic [W-1:0] t_q, a_q, t_d, d_top, r_top, r_wr;
  logic         d_err, r_err;
  stack_ctl_t   ctl;

  alu_unit #(.W(W)) u_alu (
    .valid_i (op_valid_i),
    .op_i    (op_i),
    .t_i     (t_q),
    .s_i     (d_top),
    .r_i     (r_top),
    .a_i     (a_q),
    .data_i  (data_i),
    .t_o     (t_d),
    .r_wr_o  (r_wr),
    .ctl_o   (ctl)
  );

  lifo_ring #(.W(W), .DEPTH(DDEPTH)) u_dstack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ctl.d_push),
    .pop_i     (ctl.d_pop),
    .set_top_i (1'b0),
    .wr_i      (t_q),
    .top_o     (d_top),
    .err_o     (d_err)
  );

  lifo_ring #(.W(W), .DEPTH(RDEPTH)) u_rstack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (ctl.r_push),
    .pop_i     (ctl.r_pop),
    .set_top_i (ctl.r_set),
    .wr_i      (r_wr),
    .top_o     (r_top),
    .err_o     (r_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
      a_q <= '0;
    end else begin
      t_q <= t_d;
      if (ctl.a_load)     a_q <= t_q;
      else if (ctl.a_inc) a_q <= a_q + 1'b1;
    end
  end

  assign wr_data_o   = t_q;
  assign addr_o      = a_q;
  assign t_zero_o    = (t_q[W-2:0] == '0);
  assign carry_clr_o = ~t_q[W-1];
  assign stack_err_o = d_err | r_err;

  AST_XOR_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_XOR) |=> wr_data_o == ($past(wr_data_o) ^ $past(d_top))); // R3
  AST_MSTEP_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_MUL_STEP && !wr_data_o[0]) |=> $stable(wr_data_o)); // R5
  AST_MSTEP_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_MUL_STEP) |=> $stable(d_top)); // R5
  AST_A_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i == OP_T_TO_A) |=> addr_o == $past(wr_data_o)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> ($stable(wr_data_o) && $stable(addr_o))); // R10
endmodule

// File: tb/stack_alu_core_tb_top.sv
module stack_alu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 39;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op = 5'h1E;
  logic [20:0] data = '0;
  logic [20:0] wr_data, addr;
  logic        t_zero, carry_clr, stack_err;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  stack_alu_core dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .op_valid_i  (op_valid),
    .op_i        (op),
    .data_i      (data),
    .wr_data_o   (wr_data),
    .addr_o      (addr),
    .t_zero_o    (t_zero),
    .carry_clr_o (carry_clr),
    .stack_err_o (stack_err)
  );

  // {req, op, data, expected T}
  localparam logic [50:0] VEC [NVEC] = '{
    {4'd2,  5'h0A, 21'h000005, 21'h000005},  // R2 literal
    {4'd2,  5'h0A, 21'h000003, 21'h000003},
    {4'd3,  5'h17, 21'h0,      21'h000008},  // R3 add small
    {4'd2,  5'h0A, 21'h0FFFFF, 21'h0FFFFF},
    {4'd2,  5'h0A, 21'h000001, 21'h000001},
    {4'd4,  5'h17, 21'h0,      21'h100000},  // R4 carry into bit 20
    {4'd2,  5'h0A, 21'h1FFFFF, 21'h1FFFFF},
    {4'd3,  5'h15, 21'h0,      21'h100000},  // R3 and
    {4'd6,  5'h12, 21'h0,      21'h180000},  // R6 right shift keeps bit 20
    {4'd6,  5'h12, 21'h0,      21'h1C0000},
    {4'd6,  5'h11, 21'h0,      21'h180000},  // R6 left shift
    {4'd7,  5'h10, 21'h0,      21'h07FFFF},  // R7 invert
    {4'd3,  5'h14, 21'h0,      21'h07FFF7},  // R3 xor
    {4'd2,  5'h1A, 21'h0,      21'h07FFF7},  // R2 dup
    {4'd3,  5'h14, 21'h0,      21'h000000},
    {4'd2,  5'h0A, 21'h000003, 21'h000003},
    {4'd2,  5'h0A, 21'h000006, 21'h000006},
    {4'd5,  5'h13, 21'h0,      21'h000006},  // R5 step skipped
    {4'd10, 5'h1F, 21'h0,      21'h000003},  // R10 drop
    {4'd2,  5'h0A, 21'h000005, 21'h000005},
    {4'd5,  5'h13, 21'h0,      21'h000008},  // R5 step taken
    {4'd2,  5'h1B, 21'h0,      21'h000003},  // R2 over, shows next kept
    {4'd8,  5'h1C, 21'h0,      21'h000008},  // R8 T to R
    {4'd9,  5'h1D, 21'h0,      21'h000003},  // R9 T to A
    {4'd9,  5'h19, 21'h0,      21'h000008},
    {4'd9,  5'h09, 21'h000ABC, 21'h000ABC},  // R9 fetch, A+1
    {4'd9,  5'h19, 21'h0,      21'h000009},
    {4'd9,  5'h0D, 21'h0,      21'h000ABC},  // R9 store, A+1
    {4'd9,  5'h19, 21'h0,      21'h00000A},
    {4'd9,  5'h08, 21'h001234, 21'h001234},  // R9 fetch, R top+1
    {4'd8,  5'h18, 21'h0,      21'h000004},  // R8 R to T
    {4'd10, 5'h1E, 21'h0,      21'h000004},
    {4'd10, 5'h05, 21'h0,      21'h000004},
    {4'd10, 5'h0E, 21'h0,      21'h000004},
    {4'd10, 5'h16, 21'h0,      21'h000004},
    {4'd10, 5'h0F, 21'h0,      21'h001234},  // R10 store pops
    {4'd2,  5'h0A, 21'h100001, 21'h100001},
    {4'd2,  5'h0A, 21'h100001, 21'h100001},
    {4'd4,  5'h17, 21'h0,      21'h000002}   // R4 operand bit 20 ignored
  };

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] o, input logic [20:0] d);
    op = o; data = d; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic do_reset();
    op_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_reset();
    check("R1 T", wr_data, 21'h0);
    check("R1 A", addr, 21'h0);
    check("R1 flags", {18'h0, t_zero, carry_clr, stack_err}, 21'h6);
  endtask

  initial begin
    do_reset();
    check_reset();

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][46:42], VEC[i][41:21]);
      n_chk++;
      if (wr_data !== VEC[i][20:0]) begin
        n_bad++;
        $display("FAIL R%0d vec %0d op %h actual=%h expected=%h",
                 VEC[i][50:47], i, VEC[i][46:42], wr_data, VEC[i][20:0]);
      end
    end
    check("R12 no error in normal use", {20'h0, stack_err}, 21'h0);
    check("R9 A after table", addr, 21'h00000A);

    // R11 flags
    step(5'h0A, 21'h100000);
    check("R11 zero/carry flags", {19'h0, t_zero, carry_clr}, 21'h2);
    step(5'h0A, 21'h000010);
    check("R11 nonzero flags", {19'h0, t_zero, carry_clr}, 21'h1);

    // R10 valid low: drop code presented but not executed
    op = 5'h1F; op_valid = 1'b0;
    @(negedge clk);
    check("R10 idle T", wr_data, 21'h000010);
    check("R10 idle A", addr, 21'h00000A);

    // R1 reset again, then R12 overflow and wrap
    do_reset();
    check_reset();
    for (int k = 1; k <= 18; k++) step(5'h0A, 21'(k));
    check("R12 full not error", {20'h0, stack_err}, 21'h0);
    step(5'h0A, 21'd19);
    check("R12 overflow error", {20'h0, stack_err}, 21'h1);
    for (int k = 0; k < 18; k++) step(5'h1F, 21'h0);
    check("R12 wrap kept newer", wr_data, 21'h000001);
    check("R12 sticky", {20'h0, stack_err}, 21'h1);

    // R12 return underflow, R13 single-cycle result
    do_reset();
    step(5'h18, 21'h0);
    check("R12 return underflow", {20'h0, stack_err}, 21'h1);
    step(5'h0A, 21'h00ABCD);
    check("R13 one-cycle result", wr_data, 21'h00ABCD);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule